// File: doc/BRIEF.md
# Shared Register Ownership Arbiter

Two peripheral boards sit on one processor data bus and decode overlapping register addresses. This block lives on the primary board. It decodes the primary board's four local registers and decides which board owns the shared addresses at any moment. It issues a register strobe for each decoded access on the primary side. It passes a gated copy of the data-valid strobe to the secondary board, and only while that board owns access.

A selector register splits the bank address into eight sub-registers. Its 3-bit field is loaded from bits 6:4 of a write to the selector address. Ownership moves in four cases. A selector write that picks sub-register 6 hands access over. Writes of certain codes to sub-register 5 hand access over, either until it is reclaimed or for one strobe only. Any read of the reclaim address takes access back.

An access is one cycle with `dv_i` high. Ownership is registered on that edge, so the triggering access is still served by the old owner, and the new owner serves the next strobe.

Top module: `shr_reg_arbiter`

## Requirements
- R1: Reset, which is asynchronous and active low, gives ownership to the primary board and clears the sub-address to 0.
- R2: While the primary board owns access, a strobe raises exactly one bit of `pri_stb_o` in the same cycle: bit 0 for 0x7A (bank), bit 1 for 0x78 (selector), bit 2 for 0xFA (auxiliary), bit 3 for 0xFB (reclaim). Any other address raises none, and `sec_dv_o` stays low.
- R3: While the secondary board owns access, `sec_dv_o` equals `dv_i` and bits 2:0 of `pri_stb_o` stay low.
- R4: A write to 0x78 while the primary board owns access loads `data_i[6:4]` into `sub_addr_o`, visible from the next cycle. A read of 0x78 leaves the sub-address unchanged.
- R5: A write to 0x78 whose bits 6:4 are 110 passes ownership to the secondary board from the next strobe until it is reclaimed.
- R6: A write to 0x7A with sub-address 5 and bits 6:5 equal to 11 passes ownership to the secondary board from the next strobe until it is reclaimed.
- R7: A write to 0x7A with sub-address 5 and bits 6:5 equal to 10 gives the secondary board exactly the next strobe. The strobe after that goes to the primary board.
- R8: A write to 0x7A with bits 6:5 equal to 00 or 01, or to any sub-address other than 5, leaves ownership unchanged.
- R9: A read of 0xFB returns ownership to the primary board from the next strobe, whatever the prior owner. An access to 0xFB raises `pri_stb_o[3]` whichever board owns access. A write to 0xFB does not reclaim.
- R10: Accesses made while the secondary board owns access neither change the sub-address nor trigger a handoff.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Processor register address |
| data_i | input | 8 | Processor write data |
| rd_i | input | 1 | 1 = read, 0 = write |
| dv_i | input | 1 | Data-valid strobe, one cycle per access |
| sec_dv_o | output | 1 | Gated data-valid to the secondary board |
| pri_stb_o | output | 4 | Primary register strobes: bank, selector, auxiliary, reclaim |
| sub_addr_o | output | 3 | Bank sub-register selector |

## Verification
A wrong ownership state shows at the ports on the very next strobe. Either `sec_dv_o` and the primary strobes appear together where they must not, or they swap sides. A one-shot grant that does not expire shows up as a second forwarded strobe. A corrupted selector shows in `sub_addr_o` one cycle after the write. It also shows as a wrong handoff decision on the next bank write, because the sub-register 5 codes then act on the wrong sub-register. The stimulus sequence therefore follows every trigger with at least one probing access.

// File: rtl/shr_arb_pkg.sv
`timescale 1ns/1ps
package shr_arb_pkg;
  typedef enum logic [1:0] {
    OWN_PRI      = 2'd0,
    OWN_SEC      = 2'd1,
    OWN_SEC_ONCE = 2'd2
  } owner_e;

  localparam int STB_BANK    = 0;
  localparam int STB_SEL     = 1;
  localparam int STB_AUX     = 2;
  localparam int STB_RECLAIM = 3;
  localparam int NUM_STB     = 4;
endpackage

// File: rtl/shr_addr_decode.sv
`timescale 1ns/1ps
module shr_addr_decode #(
  parameter int ADDR_W  = 8,
  parameter int NUM_STB = 4,
  parameter logic [NUM_STB*ADDR_W-1:0] MAP = '0
) (
  input  logic [ADDR_W-1:0]  addr_i,
  output logic [NUM_STB-1:0] hit_o
);
  for (genvar i = 0; i < NUM_STB; i++) begin : g_cmp
    assign hit_o[i] = (addr_i == MAP[i*ADDR_W +: ADDR_W]);
  end
endmodule

// File: rtl/shr_sub_sel.sv
`timescale 1ns/1ps
module shr_sub_sel #(
  parameter int DATA_W  = 8,
  parameter int SEL_W   = 3,
  parameter int SEL_LSB = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [SEL_W-1:0]  sel_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sel_o <= '0;
    else if (load_i) sel_o <= data_i[SEL_LSB +: SEL_W];
  end
endmodule

// File: rtl/shr_owner_fsm.sv
`timescale 1ns/1ps
module shr_owner_fsm
  import shr_arb_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   dv_i,
  input  logic   reclaim_i,
  input  logic   grant_i,
  input  logic   grant_once_i,
  output owner_e owner_o
);
  owner_e owner_d;

  always_comb begin
    owner_d = owner_o;
    if (dv_i) begin
      if (reclaim_i) owner_d = OWN_PRI;
      else begin
        unique case (owner_o)
          OWN_PRI: begin
            if (grant_i)           owner_d = OWN_SEC;
            else if (grant_once_i) owner_d = OWN_SEC_ONCE;
          end
          OWN_SEC_ONCE: owner_d = OWN_PRI;  // single strobe consumed
          default:      owner_d = owner_o;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) owner_o <= OWN_PRI;
    else         owner_o <= owner_d;
  end
endmodule

// File: rtl/shr_reg_arbiter.sv
`timescale 1ns/1ps
module shr_reg_arbiter
  import shr_arb_pkg::*;
#(
  parameter int          ADDR_W       = 8,
  parameter int          DATA_W       = 8,
  parameter int          SEL_W        = 3,
  parameter int          SEL_LSB      = 4,
  parameter int          MODE_LSB     = 5,
  parameter logic [7:0]  ADDR_BANK    = 8'h7A,
  parameter logic [7:0]  ADDR_SEL     = 8'h78,
  parameter logic [7:0]  ADDR_AUX     = 8'hFA,
  parameter logic [7:0]  ADDR_RECLAIM = 8'hFB,
  parameter int          HANDOFF_SEL  = 6,
  parameter int          MODE_SUB     = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  data_i,
  input  logic               rd_i,
  input  logic               dv_i,
  output logic               sec_dv_o,
  output logic [3:0]         pri_stb_o,
  output logic [SEL_W-1:0]   sub_addr_o
);
  localparam logic [NUM_STB*ADDR_W-1:0] MAP = {
    ADDR_W'(ADDR_RECLAIM), ADDR_W'(ADDR_AUX), ADDR_W'(ADDR_SEL), ADDR_W'(ADDR_BANK)};
  localparam logic [1:0] MODE_KEEP = 2'b11;
  localparam logic [1:0] MODE_ONCE = 2'b10;

  logic [NUM_STB-1:0] hit;
  owner_e             owner_q;
  logic               pri_own;
  logic               sel_wr, bank_mode_wr;
  logic [1:0]         mode_f;
  logic               grant, grant_once, reclaim;

  shr_addr_decode #(.ADDR_W(ADDR_W), .NUM_STB(NUM_STB), .MAP(MAP)) u_dec (
    .addr_i (addr_i),
    .hit_o  (hit)
  );

  assign pri_own  = (owner_q == OWN_PRI);
  assign sec_dv_o = dv_i & ~pri_own;

  // reclaim register is decoded by the primary board alone
  for (genvar i = 0; i < NUM_STB; i++) begin : g_stb
    if (i == STB_RECLAIM) begin : g_any
      assign pri_stb_o[i] = dv_i & hit[i];
    end else begin : g_own
      assign pri_stb_o[i] = dv_i & hit[i] & pri_own;
    end
  end

  assign sel_wr       = pri_stb_o[STB_SEL] & ~rd_i;
  assign mode_f       = data_i[MODE_LSB +: 2];
  assign bank_mode_wr = pri_stb_o[STB_BANK] & ~rd_i & (sub_addr_o == SEL_W'(MODE_SUB));
  assign grant        = (sel_wr & (data_i[SEL_LSB +: SEL_W] == SEL_W'(HANDOFF_SEL)))
                      | (bank_mode_wr & (mode_f == MODE_KEEP));
  assign grant_once   = bank_mode_wr & (mode_f == MODE_ONCE);
  assign reclaim      = pri_stb_o[STB_RECLAIM] & rd_i;

  shr_sub_sel #(.DATA_W(DATA_W), .SEL_W(SEL_W), .SEL_LSB(SEL_LSB)) u_sel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (sel_wr),
    .data_i (data_i),
    .sel_o  (sub_addr_o)
  );

  shr_owner_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .dv_i         (dv_i),
    .reclaim_i    (reclaim),
    .grant_i      (grant),
    .grant_once_i (grant_once),
    .owner_o      (owner_q)
  );
endmodule

// File: rtl/shr_reg_arbiter_chk.sv
`timescale 1ns/1ps
module shr_reg_arbiter_chk
  import shr_arb_pkg::*;
#(
  parameter int         ADDR_W       = 8,
  parameter int         DATA_W       = 8,
  parameter int         SEL_W        = 3,
  parameter int         SEL_LSB      = 4,
  parameter logic [7:0] ADDR_SEL     = 8'h78,
  parameter logic [7:0] ADDR_RECLAIM = 8'hFB,
  parameter int         HANDOFF_SEL  = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] data_i,
  input logic              rd_i,
  input logic              dv_i,
  input logic              sec_dv_o,
  input logic [3:0]        pri_stb_o,
  input logic [SEL_W-1:0]  sub_addr_o,
  input owner_e            owner_q
);
  a_r2_onehot_stb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pri_stb_o));

  a_r3_gated_dv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_dv_o |-> (dv_i && pri_stb_o[2:0] == 3'b000));

  a_r9_reclaim: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dv_i && rd_i && addr_i == ADDR_W'(ADDR_RECLAIM)) |=> (owner_q == OWN_PRI));

  a_r7_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dv_i && owner_q == OWN_SEC_ONCE) |=> (owner_q == OWN_PRI));

  a_r5_handoff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dv_i && !rd_i && !sec_dv_o && addr_i == ADDR_W'(ADDR_SEL) &&
     data_i[SEL_LSB +: SEL_W] == SEL_W'(HANDOFF_SEL))
    |=> (owner_q == OWN_SEC && sub_addr_o == SEL_W'(HANDOFF_SEL)));

  a_r10_sub_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pri_stb_o[1] && !rd_i) |=> $stable(sub_addr_o));

  a_r3_owner_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dv_i |=> $stable(owner_q));
endmodule

bind shr_reg_arbiter shr_reg_arbiter_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W), .SEL_LSB(SEL_LSB),
  .ADDR_SEL(ADDR_SEL), .ADDR_RECLAIM(ADDR_RECLAIM), .HANDOFF_SEL(HANDOFF_SEL)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .data_i(data_i), .rd_i(rd_i),
  .dv_i(dv_i), .sec_dv_o(sec_dv_o), .pri_stb_o(pri_stb_o), .sub_addr_o(sub_addr_o),
  .owner_q(owner_q)
);

// File: tb/tb_shr_reg_arbiter.sv
`timescale 1ns/1ps
module tb_shr_reg_arbiter;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] data = '0;
  logic       rd = 1'b0;
  logic       dv = 1'b0;
  logic       sec_dv;
  logic [3:0] stb;
  logic [2:0] sub;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  shr_reg_arbiter dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .data_i(data), .rd_i(rd),
    .dv_i(dv), .sec_dv_o(sec_dv), .pri_stb_o(stb), .sub_addr_o(sub)
  );

  // {rd, addr, data, exp_sec_dv, exp_stb, exp_sub_after, req}
  localparam int NV = 22;
  localparam logic [28:0] VEC [NV] = '{
    {1'b0, 8'hFA, 8'h00, 1'b0, 4'b0100, 3'd0, 4'd2},   // R2 aux write
    {1'b1, 8'h7A, 8'h00, 1'b0, 4'b0001, 3'd0, 4'd2},   // R2 bank read
    {1'b0, 8'h55, 8'h00, 1'b0, 4'b0000, 3'd0, 4'd2},   // R2 unmapped
    {1'b0, 8'h78, 8'h30, 1'b0, 4'b0010, 3'd3, 4'd4},   // R4 load 3
    {1'b1, 8'h78, 8'h60, 1'b0, 4'b0010, 3'd3, 4'd4},   // R4 read no load
    {1'b0, 8'h78, 8'h50, 1'b0, 4'b0010, 3'd5, 4'd4},   // R4 load 5
    {1'b0, 8'h7A, 8'h20, 1'b0, 4'b0001, 3'd5, 4'd8},   // R8 code 01
    {1'b0, 8'h7A, 8'h40, 1'b0, 4'b0001, 3'd5, 4'd7},   // R7 one-shot trigger
    {1'b0, 8'hFA, 8'h00, 1'b1, 4'b0000, 3'd5, 4'd7},   // R7 single strobe forwarded
    {1'b0, 8'hFA, 8'h00, 1'b0, 4'b0100, 3'd5, 4'd7},   // R7 back to primary
    {1'b0, 8'h7A, 8'h60, 1'b0, 4'b0001, 3'd5, 4'd6},   // R6 persistent trigger
    {1'b0, 8'h78, 8'h10, 1'b1, 4'b0000, 3'd5, 4'd10},  // R10 selector ignored
    {1'b1, 8'h7A, 8'h00, 1'b1, 4'b0000, 3'd5, 4'd3},   // R3 forwarded
    {1'b1, 8'hFB, 8'h00, 1'b1, 4'b1000, 3'd5, 4'd9},   // R9 reclaim read
    {1'b0, 8'h78, 8'h60, 1'b0, 4'b0010, 3'd6, 4'd5},   // R5 handoff via selector
    {1'b0, 8'hFA, 8'h00, 1'b1, 4'b0000, 3'd6, 4'd5},   // R5 secondary owns
    {1'b0, 8'hFB, 8'h00, 1'b1, 4'b1000, 3'd6, 4'd9},   // R9 write no reclaim
    {1'b0, 8'hFA, 8'h00, 1'b1, 4'b0000, 3'd6, 4'd9},   // R9 still secondary
    {1'b1, 8'hFB, 8'h00, 1'b1, 4'b1000, 3'd6, 4'd9},   // R9 reclaim
    {1'b0, 8'h78, 8'h20, 1'b0, 4'b0010, 3'd2, 4'd4},   // R4 load 2
    {1'b0, 8'h7A, 8'h60, 1'b0, 4'b0001, 3'd2, 4'd8},   // R8 code 11 at sub 2
    {1'b0, 8'hFA, 8'h00, 1'b0, 4'b0100, 3'd2, 4'd8}    // R8 no handoff
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic r, input logic [7:0] a, input logic [7:0] d,
                        input logic es, input logic [3:0] est, input logic [2:0] esub,
                        input string req);
    @(negedge clk);
    rd = r; addr = a; data = d; dv = 1'b1;
    #1;
    chk(req, "sec_dv", int'(sec_dv), int'(es));
    chk(req, "pri_stb", int'(stb), int'(est));
    @(negedge clk);
    dv = 1'b0;
    #1;
    chk(req, "sub_addr", int'(sub), int'(esub));
  endtask

  initial begin
    #1;
    chk("R1", "sub_addr in reset", int'(sub), 0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    chk("R1", "sec_dv idle", int'(sec_dv), 0);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][28], VEC[i][27:20], VEC[i][19:12], VEC[i][11], VEC[i][10:7],
             VEC[i][6:4], $sformatf("R%0d", VEC[i][3:0]));
    end

    // R5 with bit 7 set still picks sub-register 6
    access(1'b0, 8'h78, 8'hE0, 1'b0, 4'b0010, 3'd6, "R5");
    // R3: no strobe, nothing forwarded
    @(negedge clk);
    addr = 8'hFA; rd = 1'b0; dv = 1'b0;
    #1;
    chk("R3", "sec_dv without dv", int'(sec_dv), 0);
    chk("R3", "pri_stb without dv", int'(stb), 0);
    // R1: reset while the secondary owns access
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk("R1", "sub_addr async clear", int'(sub), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    access(1'b0, 8'hFA, 8'h00, 1'b0, 4'b0100, 3'd0, "R1");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule